// File: doc/BRIEF.md
# Quadrature Edge Decoder with Direction Tracking

This block turns a pair of quadrature signals, channel A and channel B, into count steps for a signed position counter. Both channels are sampled on the system clock through a two-stage synchronizer. An edge is found by comparing each synchronized level with the level it had one cycle earlier. Every rising and every falling edge on either channel produces one count step, so a full input period gives four steps.

A small state machine records which of the four possible edges was seen most recently. It uses that record to decide whether a new edge means forward or backward motion. A repeated edge on the channel that moved last reverses the direction, and the step is taken in the reversed direction. Edges on both channels in the same sample cannot be ordered. Such an event leaves the counter and direction untouched and sets a sticky phase-error flag. The flag can raise an interrupt output when that output is enabled. A swap input exchanges the channels after the synchronizer, which reverses the sense of counting.

Top module: `quad_edge_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `position` becomes 0, `dir_up` becomes 1, `phase_err`, `irq` and `cnt_pulse` become 0, and the last-edge record becomes "none".
- R2: Each single-channel edge (one of A or B changes between two consecutive synchronized samples) produces exactly one `cnt_pulse` lasting one cycle, and `position` then moves by exactly 1. A full input period therefore yields four steps.
- R3: With A leading B (A rises, B rises, A falls, B falls), each step counts up: `cnt_up` and `dir_up` are 1 and `position` increments.
- R4: With B leading A (B rises, A rises, B falls, A falls, or any contiguous part of this sequence), each step counts down: `cnt_up` and `dir_up` are 0 and `position` decrements.
- R5: An edge on the same channel as the previous edge inverts `dir_up`, and that edge steps `position` one count in the new direction.
- R6: The first edge after reset steps `position` in the current direction (up) and changes nothing else except the last-edge record.
- R7: Edges on both channels in the same synchronized sample give no `cnt_pulse`, leave `position` and `dir_up` unchanged, and set `phase_err`. The flag stays 1 until a cycle with `err_clr` high and no new phase error, after which it reads 0.
- R8: `irq` equals `phase_err` AND `irq_en` at all times.
- R9: With `swap` high, the inputs are exchanged before decoding, so an A-leading sequence counts down after its first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 1 | Quadrature channel A, asynchronous |
| in_b | input | 1 | Quadrature channel B, asynchronous |
| swap | input | 1 | 1 exchanges A and B ahead of the decoder |
| irq_en | input | 1 | Enables the phase-error interrupt |
| err_clr | input | 1 | Pulse high to clear the phase-error flag |
| cnt_pulse | output | 1 | One-cycle count step |
| cnt_up | output | 1 | Direction of the current step, 1 = up |
| dir_up | output | 1 | Direction status, 1 = up |
| phase_err | output | 1 | Sticky phase-error flag |
| irq | output | 1 | Phase-error interrupt |
| position | output | CNT_W (16) | Signed position count |

## Verification
An input change driven between clock edges is captured at the first rising edge and reaches the second synchronizer stage at the second. The decoder registers `cnt_pulse`, `cnt_up` and `dir_up` at the third edge. `position` and `phase_err` follow at the fourth edge, one register further on, while `irq` follows `phase_err` combinationally. The bench changes inputs only at falling edges. It samples the decoder outputs 1 ns after the third rising edge, and `position` and `phase_err` 1 ns after the fourth, at which point it also confirms that the pulse has dropped. An `err_clr` or `irq_en` change is checked 1 ns after the edge that registers it, or immediately for the combinational interrupt.

// File: rtl/qdec_pkg.sv
// Shared types and the direction decision used by the quadrature decoder.
// Assumes the edge code bits: [2] valid, [1] channel (1 = B), [0] rising.
package qdec_pkg;

    typedef enum logic [2:0] {
        EDGE_NONE   = 3'b000,
        EDGE_A_FALL = 3'b100,
        EDGE_A_RISE = 3'b101,
        EDGE_B_FALL = 3'b110,
        EDGE_B_RISE = 3'b111
    } edge_kind_e;

    // Decide the direction after edge 'now_e' given the previous edge 'last_e'.
    function automatic logic next_direction(edge_kind_e last_e, edge_kind_e now_e, logic dir_now);
        logic [2:0] lb;
        logic [2:0] nb;
        lb = last_e;
        nb = now_e;
        if (!lb[2]) begin
            return dir_now;
        end else if (lb[1] == nb[1]) begin
            return !dir_now;
        end else if (!lb[1]) begin
            return (lb[0] == nb[0]);
        end else begin
            return (lb[0] != nb[0]);
        end
    endfunction

endpackage

// File: rtl/qdec_sync.sv
// Multi-stage synchronizer with a one-cycle history register per bit.
// Assumes STAGES >= 1; all flops reset to 0, so inputs should idle low at reset.
module qdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Shift the sampled inputs one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= din;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Hold the last synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= stage_q[STAGES-1];
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;
endmodule

// File: rtl/qdec_step.sv
// Edge classifier and direction state machine. Registers one step per
// single-channel edge and an error event when both channels move together.
// Assumes cur/prev come from the same synchronizer sample pair.
module qdec_step
    import qdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_cur,
    input  logic a_prev,
    input  logic b_cur,
    input  logic b_prev,
    output logic cnt_pulse,
    output logic cnt_up,
    output logic dir_up,
    output logic err_evt
);
    edge_kind_e last_q, last_d, this_edge;
    logic dir_q, dir_d, pulse_q, pulse_d, up_q, err_q, err_d;
    logic a_moved, b_moved;

    assign a_moved = a_cur ^ a_prev;
    assign b_moved = b_cur ^ b_prev;

    // Classify the present edge and pick the next direction and record.
    always_comb begin
        this_edge = EDGE_NONE;
        if (a_moved) this_edge = a_cur ? EDGE_A_RISE : EDGE_A_FALL;
        else if (b_moved) this_edge = b_cur ? EDGE_B_RISE : EDGE_B_FALL;
        last_d  = last_q;
        dir_d   = dir_q;
        pulse_d = 1'b0;
        err_d   = 1'b0;
        if (a_moved && b_moved) begin
            err_d = 1'b1;
        end else if (a_moved || b_moved) begin
            pulse_d = 1'b1;
            dir_d   = next_direction(last_q, this_edge, dir_q);
            last_d  = this_edge;
        end
    end

    // Register the decision state and the step outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= EDGE_NONE;
            dir_q   <= 1'b1;
            pulse_q <= 1'b0;
            up_q    <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            last_q  <= last_d;
            dir_q   <= dir_d;
            pulse_q <= pulse_d;
            up_q    <= dir_d;
            err_q   <= err_d;
        end
    end

    assign cnt_pulse = pulse_q;
    assign cnt_up    = up_q;
    assign dir_up    = dir_q;
    assign err_evt   = err_q;

    AST_STEP_DIR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pulse |-> (cnt_up == dir_up)) else $error("step direction mismatch"); // R5
    AST_DIR_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_pulse |-> $stable(dir_up)) else $error("direction changed without step"); // R7
    AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |-> !cnt_pulse) else $error("step on phase error"); // R7
endmodule

// File: rtl/qdec_errflag.sv
// Sticky phase-error flag: set by an error event, cleared by a clear pulse.
// Assumes a set in the same cycle as a clear wins.
module qdec_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    // Hold the flag until cleared; a new error takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag) else $error("flag lost without clear"); // R7
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag) else $error("flag not set"); // R7
endmodule

// File: rtl/qdec_poscnt.sv
// Signed up/down position counter advanced by one per step, wrapping in
// two's complement. Assumes step_up is valid whenever step_en is high.
module qdec_poscnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    output logic [CNT_W-1:0] position
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    logic [CNT_W-1:0] pos_q;

    // Move the count one step in the requested direction.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else if (step_en) pos_q <= step_up ? pos_q + ONE : pos_q - ONE;
    end

    assign position = pos_q;

    AST_POS_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up) |=> (position == $past(position) + ONE)) else $error("bad increment"); // R2
    AST_POS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up) |=> (position == $past(position) - ONE)) else $error("bad decrement"); // R2
    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(position)) else $error("count moved without step"); // R7
endmodule

// File: rtl/quad_edge_decoder.sv
// Quadrature edge decoder top: synchronizes A/B, optionally swaps them,
// decodes each edge into a step with direction, keeps a sticky phase-error
// flag with gated interrupt, and drives a signed position counter.
// Assumes inputs idle low during reset.
module quad_edge_decoder #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_a,
    input  logic             in_b,
    input  logic             swap,
    input  logic             irq_en,
    input  logic             err_clr,
    output logic             cnt_pulse,
    output logic             cnt_up,
    output logic             dir_up,
    output logic             phase_err,
    output logic             irq,
    output logic [CNT_W-1:0] position
);
    localparam int CH = 2;

    logic [CH-1:0] s_cur, s_prev;
    logic a_cur, a_prev, b_cur, b_prev;
    logic err_evt;

    qdec_sync #(.W(CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({in_b, in_a}),
        .cur(s_cur), .prev(s_prev)
    );

    // Exchange channels after synchronization so a swap change makes no edge.
    always_comb begin
        a_cur  = swap ? s_cur[1]  : s_cur[0];
        a_prev = swap ? s_prev[1] : s_prev[0];
        b_cur  = swap ? s_cur[0]  : s_cur[1];
        b_prev = swap ? s_prev[0] : s_prev[1];
    end

    qdec_step u_step (
        .clk(clk), .rst_n(rst_n),
        .a_cur(a_cur), .a_prev(a_prev), .b_cur(b_cur), .b_prev(b_prev),
        .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .dir_up(dir_up), .err_evt(err_evt)
    );

    qdec_errflag u_err (
        .clk(clk), .rst_n(rst_n), .set(err_evt), .clr(err_clr), .flag(phase_err)
    );

    qdec_poscnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_en(cnt_pulse), .step_up(cnt_up),
        .position(position)
    );

    assign irq = phase_err & irq_en;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq) else $error("interrupt while disabled"); // R8
endmodule

// File: tb/sim_quad_edge_decoder.sv
module sim_quad_edge_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, swap = 1'b0, irq_en = 1'b0, err_clr = 1'b0;
    logic cnt_pulse, cnt_up, dir_up, phase_err, irq;
    logic [15:0] position;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    quad_edge_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .swap(swap),
        .irq_en(irq_en), .err_clr(err_clr), .cnt_pulse(cnt_pulse),
        .cnt_up(cnt_up), .dir_up(dir_up), .phase_err(phase_err), .irq(irq),
        .position(position)
    );

    // {a, b, pulse, dir, position}
    localparam logic [19:0] VEC [13] = '{
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd1},      // R6 first edge counts up
        {1'b1, 1'b1, 1'b1, 1'b1, 16'd2},      // R3
        {1'b0, 1'b1, 1'b1, 1'b1, 16'd3},      // R3
        {1'b0, 1'b0, 1'b1, 1'b1, 16'd4},      // R2 four steps per period
        {1'b1, 1'b0, 1'b1, 1'b1, 16'd5},      // R3
        {1'b0, 1'b0, 1'b1, 1'b0, 16'd4},      // R5 repeat on A reverses
        {1'b0, 1'b1, 1'b1, 1'b0, 16'd3},      // R4
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd2},      // R4
        {1'b1, 1'b0, 1'b1, 1'b0, 16'd1},      // R4
        {1'b0, 1'b0, 1'b1, 1'b0, 16'd0},      // R4
        {1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF},   // R4 below zero
        {1'b0, 1'b0, 1'b1, 1'b1, 16'd0},      // R5 repeat on B reverses
        {1'b1, 1'b1, 1'b0, 1'b1, 16'd0}       // R7 both move: no step
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic a, logic b, logic ep, logic ed, logic [15:0] epos, string req);
        @(negedge clk);
        in_a = a;
        in_b = b;
        repeat (3) @(posedge clk);
        #1;
        check(req, "cnt_pulse", 32'(cnt_pulse), 32'(ep));
        check(req, "dir_up", 32'(dir_up), 32'(ed));
        if (ep) check(req, "cnt_up", 32'(cnt_up), 32'(ed));
        @(posedge clk);
        #1;
        check(req, "position", 32'(position), 32'(epos));
        check("R2", "pulse width", 32'(cnt_pulse), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_a = 1'b0;
        in_b = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R1", "position", 32'(position), 32'd0);
        check("R1", "dir_up", 32'(dir_up), 32'd1);
        check("R1", "phase_err", 32'(phase_err), 32'd0);
        check("R1", "cnt_pulse", 32'(cnt_pulse), 32'd0);
        check("R1", "irq", 32'(irq), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < 13; i++) begin
            drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0], "R2-R7 table");
        end
        check("R7", "phase_err set", 32'(phase_err), 32'd1);
        check("R8", "irq disabled", 32'(irq), 32'd0);

        repeat (5) @(posedge clk);
        #1;
        check("R7", "phase_err sticky", 32'(phase_err), 32'd1);
        check("R7", "position held", 32'(position), 32'd0);

        @(negedge clk);
        irq_en = 1'b1;
        #1;
        check("R8", "irq enabled", 32'(irq), 32'd1);

        @(negedge clk);
        err_clr = 1'b1;
        @(posedge clk);
        #1;
        check("R7", "phase_err cleared", 32'(phase_err), 32'd0);
        check("R8", "irq after clear", 32'(irq), 32'd0);
        @(negedge clk);
        err_clr = 1'b0;
        irq_en = 1'b0;

        // R9: swapped channels reverse an A-leading sequence.
        swap = 1'b1;
        do_reset();
        drive(1'b1, 1'b0, 1'b1, 1'b1, 16'd1, "R9");
        drive(1'b1, 1'b1, 1'b1, 1'b0, 16'd0, "R9");
        drive(1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, "R9");
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFE, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule